// File: doc/BRIEF.md
# Display serial command queue packet builder

This block turns one display-link command into the word image that a link engine reads from its command queue. A command arrives as a data type byte and a payload length. The payload bytes then stream in one at a time. The block first waits for the link engine to go idle. It then clears the engine's interrupt status and packs the header and payload into 32-bit queue words. After the words it writes the queue word count, drives the start control low and then high, and waits for the engine's command-done flag. One response pulse reports success, a busy timeout or a done timeout.

The block picks one of two packet layouts. In the short layout the header word carries up to two payload bytes. In the long layout the header carries the length and is followed by little-endian payload words. Read requests set the bus-turnaround configuration code.

Both timeouts are counted in clock cycles. The counts come from a clock-frequency parameter in kHz and the two wait limits in microseconds. By default these are 20000 us for busy and 400 us for done.

Top module: `cmdq_builder`

## Requirements
- R1: Header bits 7:0 hold the configuration code. Types 8'h04, 8'h14, 8'h24 and 8'h06 (read requests) give 8'h04 (turnaround). Any other type gives 8'h02 when the length is above 2 and 8'h00 otherwise. Header bits 15:8 hold the type.
- R2: For a length of 0 to 2, queue word 0 is the only word written. Payload byte i sits at bits (i+2)*8+7:(i+2)*8, absent bytes are zero, and the queue size written is 1.
- R3: For a length above 2, word 0 bits 31:16 hold the length. Payload byte n goes to word 1+n/4, at bits (n%4)*8+7:(n%4)*8. The queue size written is 1+ceil(length/4), and exactly that many words are written.
- R4: In a partly filled final payload word, the bytes beyond the length are zero.
- R5: While busy is high, nothing is cleared, written or started. If busy stays high for BUSY_CYC cycles of waiting, the response is code 1 with no payload consumed. That response appears BUSY_CYC+1 cycles after the command-accept cycle.
- R6: After busy clears, intClr pulses exactly once, before any queue write.
- R7: The size write follows the last queue word write. Then startWe pulses with startVal=0 and, in the next cycle, with startVal=1.
- R8: After the start=1 write, cmdDone gives response code 0. Without cmdDone, code 2 appears exactly DONE_CYC cycles after the start=1 cycle. Code 3 is never used.
- R9: A command is accepted only while cmdReady is high, which is only when the block is idle. Exactly `length` payload bytes are taken, and only after the interrupt clear. cmdReady and byteReady are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle, command taken on valid |
| cmdType | input | 8 | Packet data type |
| cmdLen | input | LEN_W | Payload length in bytes, 0..MAX_LEN |
| byteValid | input | 1 | Payload byte offered |
| byteReady | output | 1 | Block takes a payload byte |
| byteData | input | 8 | Payload byte |
| qWe | output | 1 | Queue word write strobe |
| qAddr | output | ADDR_W | Queue word index |
| qData | output | 32 | Queue word |
| qSizeWe | output | 1 | Queue size write strobe |
| qSize | output | SIZE_W | Number of valid queue words |
| intClr | output | 1 | Clear interrupt status pulse |
| startWe | output | 1 | Start control write strobe |
| startVal | output | 1 | Value written to start control |
| busy | input | 1 | Link engine busy |
| cmdDone | input | 1 | Command-done flag of the engine |
| respValid | output | 1 | One-cycle response pulse |
| respCode | output | 2 | 0 ok, 1 busy timeout, 2 done timeout |

## Verification
The assertions take for granted that cmdLen never exceeds MAX_LEN. The queue address bound and the byte-count bound rely on this. They also take for granted that busy and cmdDone are clean levels from the engine. The bench draws every length from 0..MAX_LEN. It raises cmdDone only after the start write and lowers it when it sees intClr, so a stale done flag from the previous command stays up across the busy wait. Payload bytes arrive with random gaps, and the bench offers them only while bytes of the current command remain.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [7:0] CFG_SHORT = 8'h00;
  localparam logic [7:0] CFG_LONG  = 8'h02;
  localparam logic [7:0] CFG_TURN  = 8'h04;

  localparam logic [1:0] RESP_OK      = 2'd0;
  localparam logic [1:0] RESP_BUSY_TO = 2'd1;
  localparam logic [1:0] RESP_DONE_TO = 2'd2;

  typedef struct packed {
    logic latchCmd;
    logic clrInt;
    logic takeByte;
    logic wrHeader;
    logic wrSize;
    logic start0;
    logic start1;
  } dpCtl_t;

  function automatic logic isReadType(input logic [7:0] t);
    return (t == 8'h04) || (t == 8'h14) || (t == 8'h24) || (t == 8'h06);
  endfunction
endpackage

// File: rtl/cmdq_dp.sv
module cmdq_dp
  import cmdq_pkg::*;
#(
  parameter int LEN_W  = 7,
  parameter int QDEPTH = 17,
  parameter int ADDR_W = 5,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        cmdType,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [7:0]        byteData,
  output logic              allIn,
  output logic              qWe,
  output logic [ADDR_W-1:0] qAddr,
  output logic [31:0]       qData,
  output logic              qSizeWe,
  output logic [SIZE_W-1:0] qSize,
  output logic              intClr,
  output logic              startWe,
  output logic              startVal
);
  logic [7:0]       typeQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] byteCnt;
  logic [31:0]      wordBuf;
  logic [31:0]      merged;
  logic [31:0]      header;
  logic [7:0]       cfg;
  logic [1:0]       lane;
  logic             isLong;
  logic             lastOfWord;
  logic [ADDR_W-1:0] payAddr;
  logic [SIZE_W-1:0] sizeVal;

  assign isLong     = lenQ > LEN_W'(2);
  assign lane       = byteCnt[1:0];
  assign allIn      = byteCnt == lenQ;
  assign lastOfWord = (lane == 2'd3) || (byteCnt == lenQ - LEN_W'(1));
  assign payAddr    = ADDR_W'(byteCnt >> 2) + ADDR_W'(1);

  always_comb begin
    merged = wordBuf;
    merged[{lane, 3'b000} +: 8] = byteData;
  end

  always_comb begin
    if (isReadType(typeQ))  cfg = CFG_TURN;
    else if (isLong)        cfg = CFG_LONG;
    else                    cfg = CFG_SHORT;
    if (isLong) header = {16'(lenQ), typeQ, cfg};
    else        header = {wordBuf[15:0], typeQ, cfg};
    if (isLong)
      sizeVal = SIZE_W'(((LEN_W+1)'(lenQ) + (LEN_W+1)'(3)) >> 2) + SIZE_W'(1);
    else
      sizeVal = SIZE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ   <= '0;
      lenQ    <= '0;
      byteCnt <= '0;
      wordBuf <= '0;
    end else if (ctl.latchCmd) begin
      typeQ   <= cmdType;
      lenQ    <= cmdLen;
      byteCnt <= '0;
      wordBuf <= '0;
    end else if (ctl.takeByte) begin
      byteCnt <= byteCnt + LEN_W'(1);
      wordBuf <= (isLong && lastOfWord) ? 32'h0 : merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qWe      <= 1'b0;
      qAddr    <= '0;
      qData    <= '0;
      qSizeWe  <= 1'b0;
      qSize    <= '0;
      intClr   <= 1'b0;
      startWe  <= 1'b0;
      startVal <= 1'b0;
    end else begin
      qWe      <= ctl.wrHeader || (ctl.takeByte && isLong && lastOfWord);
      qAddr    <= ctl.wrHeader ? '0 : payAddr;
      qData    <= ctl.wrHeader ? header : merged;
      qSizeWe  <= ctl.wrSize;
      qSize    <= sizeVal;
      intClr   <= ctl.clrInt;
      startWe  <= ctl.start0 || ctl.start1;
      startVal <= ctl.start1;
    end
  end

  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    qWe |-> (32'(qAddr) < QDEPTH));

  p_take_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeByte |-> !allIn);

  p_start_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startWe && startVal) |-> $past(startWe && !startVal));

  p_size_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    qSizeWe |-> (qSize != '0 && 32'(qSize) <= QDEPTH));
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 2000000,
  parameter int unsigned DONE_CYC = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic       byteValid,
  output logic       byteReady,
  input  logic       allIn,
  input  logic       busy,
  input  logic       cmdDone,
  output dpCtl_t     ctl,
  output logic       respValid,
  output logic [1:0] respCode
);
  localparam int unsigned MAX_CYC = (BUSY_CYC > DONE_CYC) ? BUSY_CYC : DONE_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_BUSY, S_CLR, S_COLLECT, S_HDR, S_SIZE, S_GO0, S_GO1, S_WAIT_DONE
  } state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             respSet;
  logic [1:0]       respNext;

  always_comb begin
    nxt       = state;
    ctl       = '0;
    cmdReady  = 1'b0;
    byteReady = 1'b0;
    respSet   = 1'b0;
    respNext  = RESP_OK;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          nxt = S_WAIT_BUSY;
        end
      end
      S_WAIT_BUSY: begin
        if (!busy) nxt = S_CLR;
        else if (cnt == CNT_W'(BUSY_CYC - 1)) begin
          nxt      = S_IDLE;
          respSet  = 1'b1;
          respNext = RESP_BUSY_TO;
        end
      end
      S_CLR: begin
        ctl.clrInt = 1'b1;
        nxt = S_COLLECT;
      end
      S_COLLECT: begin
        byteReady    = !allIn;
        ctl.takeByte = byteValid && !allIn;
        if (allIn) nxt = S_HDR;
      end
      S_HDR: begin
        ctl.wrHeader = 1'b1;
        nxt = S_SIZE;
      end
      S_SIZE: begin
        ctl.wrSize = 1'b1;
        nxt = S_GO0;
      end
      S_GO0: begin
        ctl.start0 = 1'b1;
        nxt = S_GO1;
      end
      S_GO1: begin
        ctl.start1 = 1'b1;
        nxt = S_WAIT_DONE;
      end
      S_WAIT_DONE: begin
        if (cmdDone) begin
          nxt     = S_IDLE;
          respSet = 1'b1;
        end else if (cnt == CNT_W'(DONE_CYC - 1)) begin
          nxt      = S_IDLE;
          respSet  = 1'b1;
          respNext = RESP_DONE_TO;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      respValid <= 1'b0;
      respCode  <= RESP_OK;
    end else begin
      state     <= nxt;
      respValid <= respSet;
      if (respSet) respCode <= respNext;
      if (state != nxt) cnt <= '0;
      else if (state == S_WAIT_BUSY || state == S_WAIT_DONE) cnt <= cnt + CNT_W'(1);
    end
  end

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

  p_busy_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_BUSY) |-> (32'(cnt) < BUSY_CYC));

  p_clear_after_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrInt |-> $past(!busy));

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respCode != 2'd3));

  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && byteReady));
endmodule

// File: rtl/cmdq_builder.sv
module cmdq_builder
  import cmdq_pkg::*;
#(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned BUSY_US = 20000,
  parameter int unsigned DONE_US = 400,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int QDEPTH = 1 + (MAX_LEN + 3) / 4,
  localparam int ADDR_W = $clog2(QDEPTH),
  localparam int SIZE_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdType,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic [7:0]        byteData,
  output logic              qWe,
  output logic [ADDR_W-1:0] qAddr,
  output logic [31:0]       qData,
  output logic              qSizeWe,
  output logic [SIZE_W-1:0] qSize,
  output logic              intClr,
  output logic              startWe,
  output logic              startVal,
  input  logic              busy,
  input  logic              cmdDone,
  output logic              respValid,
  output logic [1:0]        respCode
);
  localparam int unsigned BUSY_CYC = (CLK_KHZ * BUSY_US) / 1000;
  localparam int unsigned DONE_CYC = (CLK_KHZ * DONE_US) / 1000;

  dpCtl_t ctl;
  logic   allIn;

  cmdq_ctrl #(.BUSY_CYC(BUSY_CYC), .DONE_CYC(DONE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .byteValid(byteValid), .byteReady(byteReady), .allIn(allIn),
    .busy(busy), .cmdDone(cmdDone), .ctl(ctl),
    .respValid(respValid), .respCode(respCode)
  );

  cmdq_dp #(.LEN_W(LEN_W), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdType(cmdType), .cmdLen(cmdLen),
    .byteData(byteData), .allIn(allIn), .qWe(qWe), .qAddr(qAddr), .qData(qData),
    .qSizeWe(qSizeWe), .qSize(qSize), .intClr(intClr),
    .startWe(startWe), .startVal(startVal)
  );
endmodule

// File: tb/cmdq_builder_bench.sv
module cmdq_builder_bench;
  localparam int MAX_LEN  = 64;
  localparam int CLK_KHZ  = 1000;
  localparam int BUSY_US  = 20000;
  localparam int DONE_US  = 400;
  localparam int BUSY_CYC = CLK_KHZ * BUSY_US / 1000;
  localparam int DONE_CYC = CLK_KHZ * DONE_US / 1000;
  localparam int LEN_W    = $clog2(MAX_LEN + 1);
  localparam int QDEPTH   = 1 + (MAX_LEN + 3) / 4;
  localparam int ADDR_W   = $clog2(QDEPTH);
  localparam int SIZE_W   = $clog2(QDEPTH + 1);

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdReady;
  logic [7:0] cmdType = 0;
  logic [LEN_W-1:0] cmdLen = 0;
  logic byteValid = 0, byteReady;
  logic [7:0] byteData = 0;
  logic qWe, qSizeWe, intClr, startWe, startVal, respValid;
  logic [ADDR_W-1:0] qAddr;
  logic [31:0] qData;
  logic [SIZE_W-1:0] qSize;
  logic busy = 0, cmdDone = 0;
  logic [1:0] respCode;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  pay [MAX_LEN];
  logic [31:0] qmem [QDEPTH];

  cmdq_builder #(.MAX_LEN(MAX_LEN), .CLK_KHZ(CLK_KHZ), .BUSY_US(BUSY_US), .DONE_US(DONE_US))
  u_cmdq_builder (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdType(cmdType),
    .cmdLen(cmdLen), .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
    .qWe(qWe), .qAddr(qAddr), .qData(qData), .qSizeWe(qSizeWe), .qSize(qSize),
    .intClr(intClr), .startWe(startWe), .startVal(startVal), .busy(busy),
    .cmdDone(cmdDone), .respValid(respValid), .respCode(respCode)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expCfg(input logic [7:0] t, input int len);
    if (t == 8'h04 || t == 8'h14 || t == 8'h24 || t == 8'h06) return 8'h04;
    return (len > 2) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [31:0] expHdr(input logic [7:0] t, input int len);
    logic [31:0] w;
    w = {16'h0, t, expCfg(t, len)};
    if (len > 2) w[31:16] = 16'(len);
    else begin
      if (len > 0) w[23:16] = pay[0];
      if (len > 1) w[31:24] = pay[1];
    end
    return w;
  endfunction

  function automatic logic [31:0] expPay(input int k, input int len);
    logic [31:0] w = 32'h0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = pay[4*k + j];
    return w;
  endfunction

  task automatic runCmd(input logic [7:0] t, input int len, input int busyDelay,
                        input int doneDelay, input int expCode);
    int idx = 0, t0, acceptCyc = -1, clrCyc = -1, clrCnt = 0, sizeCyc = -1;
    int s0Cyc = -1, s1Cyc = -1, respCyc = -1, lastQ = -1, nW = 0, expSize;
    bit cmdFire = 0, byteFire = 0;
    logic [1:0] code = 2'd3;
    logic [SIZE_W-1:0] sz = '0;
    for (int k = 0; k < MAX_LEN; k++) pay[k] = 8'($urandom);
    for (int k = 0; k < QDEPTH; k++) qmem[k] = 32'hDEAD_BEEF;
    expSize = (len > 2) ? 1 + (len + 3) / 4 : 1;
    @(negedge clk);
    t0 = cyc;
    cmdType = t; cmdLen = LEN_W'(len); cmdValid = 1;
    for (int g = 0; g < BUSY_CYC + 2000 && respCyc < 0; g++) begin
      if (g > 0) @(negedge clk);
      if (cmdFire) begin cmdValid = 0; cmdFire = 0; end
      if (byteFire) idx++;
      busy = (busyDelay < 0) || (cyc - t0 < busyDelay);
      if (intClr) begin clrCnt++; clrCyc = cyc; cmdDone = 0; end
      if (qWe) begin
        if (clrCyc < 0) check("R6", "queue write before clear", 1, 0);
        qmem[qAddr] = qData; nW++; lastQ = cyc;
      end
      if (qSizeWe) begin sz = qSize; sizeCyc = cyc; end
      if (startWe) begin if (startVal) s1Cyc = cyc; else s0Cyc = cyc; end
      if (s1Cyc >= 0 && doneDelay >= 0 && cyc == s1Cyc + doneDelay) cmdDone = 1;
      if (respValid) begin respCyc = cyc; code = respCode; end
      byteValid = (idx < len) && ($urandom_range(3) != 0);
      byteData  = (idx < len) ? pay[idx] : 8'h00;
      if (cmdValid && cmdReady) begin cmdFire = 1; acceptCyc = cyc; end
      byteFire = byteValid && byteReady;
    end
    byteValid = 0; cmdValid = 0; busy = 0;
    if (respCyc < 0) begin
      total++; bad++;
      $display("FAIL R8 command watchdog actual=none expected=response");
      return;
    end
    check(expCode == 1 ? "R5" : "R8", "response code", code, expCode);
    if (expCode == 1) begin
      check("R5", "writes on busy timeout", nW, 0);
      check("R5", "clears on busy timeout", clrCnt, 0);
      check("R5", "start on busy timeout", s0Cyc < 0 && s1Cyc < 0, 1);
      check("R5", "bytes taken on busy timeout", idx, 0);
      check("R5", "busy timeout latency", respCyc - acceptCyc, BUSY_CYC + 1);
      return;
    end
    check("R6", "single clear", clrCnt, 1);
    if (busyDelay > 0) check("R5", "clear waited for busy", clrCyc > t0 + busyDelay, 1);
    check("R9", "bytes taken", idx, len);
    check("R1", "config code", qmem[0][7:0], expCfg(t, len));
    check("R1", "type field", qmem[0][15:8], t);
    check(len > 2 ? "R3" : "R2", "header word", qmem[0], expHdr(t, len));
    if (len > 2)
      for (int k = 0; k < (len + 3) / 4; k++)
        check((k == (len + 3) / 4 - 1 && len % 4 != 0) ? "R4" : "R3",
              $sformatf("payload word %0d", k + 1), qmem[k + 1], expPay(k, len));
    check(len > 2 ? "R3" : "R2", "words written", nW, expSize);
    check(len > 2 ? "R3" : "R2", "queue size", sz, expSize);
    check("R7", "size after last word", sizeCyc > lastQ, 1);
    check("R7", "start 0 after size", s0Cyc > sizeCyc, 1);
    check("R7", "start 1 follows start 0", s1Cyc - s0Cyc, 1);
    if (expCode == 2) check("R8", "done timeout latency", respCyc - s1Cyc, DONE_CYC);
    else check("R8", "ok response after done", respCyc - s1Cyc, doneDelay + 1);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] types [8];
    types = '{8'h05, 8'h15, 8'h39, 8'h29, 8'h04, 8'h14, 8'h24, 8'h06};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9", "reset cmdReady", cmdReady, 1);
    check("R9", "reset byteReady", byteReady, 0);
    check("R7", "reset startWe", startWe, 0);
    check("R8", "reset respValid", respValid, 0);
    check("R6", "reset intClr", intClr, 0);
    check("R3", "reset qWe", qWe, 0);
    cmdDone = 1;
    runCmd(8'h05, 0, 0, 3, 0);
    runCmd(8'h15, 1, 4, 0, 0);
    runCmd(8'h15, 2, 0, 7, 0);
    runCmd(8'h39, 3, 2, 1, 0);
    runCmd(8'h39, 4, 0, 2, 0);
    runCmd(8'h39, 5, 9, 5, 0);
    runCmd(8'h29, MAX_LEN, 0, 10, 0);
    runCmd(8'h06, 1, 0, 0, 0);
    runCmd(8'h04, 0, 1, 2, 0);
    runCmd(8'h24, 2, 0, 3, 0);
    runCmd(8'h14, 3, 0, 3, 0);
    runCmd(8'h39, 5, -1, 0, 1);
    runCmd(8'h39, 6, 0, -1, 2);
    runCmd(8'h15, 2, 0, 4, 0);
    for (int n = 0; n < 30; n++) begin
      logic [7:0] t = ($urandom_range(1) == 0) ? types[$urandom_range(7)] : 8'($urandom);
      int len = ($urandom_range(1) == 0) ? $urandom_range(6) : $urandom_range(MAX_LEN);
      runCmd(t, len, $urandom_range(20), $urandom_range(50), 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule